// File: doc/BRIEF.md
# Serial Link Low-Power Wake Controller

This block governs the power state of a byte-oriented serial link controller on a single-wire, J1850-style vehicle bus. The host CPU announces its wait instruction with a one-cycle strobe. The level of a mode select input at that moment picks one of two sleep tiers:

- **Light sleep.** The link datapath clock keeps running but transmission is inhibited.
- **Deep sleep.** The datapath clock enable is dropped.

In either tier, the first passive-to-active (low-to-high) change of the received bus level ends the sleep. A light-sleep wake raises a maskable interrupt and returns to run at once. A deep-sleep wake raises a non-maskable request carrying vector code 0x20. The datapath clock stays off until the host acknowledges that request.

The block also reports whether the message that caused the wake will be received intact. After a light-sleep wake this is always true. After a deep-sleep wake it is true only if the host read an end-of-frame status after the last bus activity and before deep sleep was entered. A sleep request made while a transmission is still active is a usage error. It raises an error flag and the block stays in run.

The received bus level is synchronized on the always-running block clock before any edge is detected. The bit-level line coding and the frame logic live elsewhere.

Top module: `linkWakeCtl`

## Requirements
- R1: After a synchronous active-high reset, the block is in run with `linkClkEn`=1 and `txInhibit`=0, and all of `wakeIrq`, `nmiReq`, `rxIntact`, `sleepErr` and `nmiVector` are 0.
- R2: If `cpuWaitStb` arrives in run with `deepModeSel`=0 and `txBusy`=0, then from the next cycle the block is in light sleep: `txInhibit`=1 and `linkClkEn`=1.
- R3: In light sleep, a 0-to-1 change of `busRx` sets `wakeIrq` on the third rising clock edge after the change (two synchronizer flops plus the state register). On that same edge the block returns to run (`txInhibit`=0) and `rxIntact` becomes 1.
- R4: If `cpuWaitStb` arrives in run with `deepModeSel`=1 and `txBusy`=0, then from the next cycle the block is in deep sleep: `linkClkEn`=0 and `txInhibit`=1. Whenever `linkClkEn` is 0, `txInhibit` is 1.
- R5: In deep sleep, a 0-to-1 change of `busRx` sets `nmiReq` on the third clock edge after the change. `nmiVector` reads 8'h20 while `nmiReq` is 1 and 8'h00 otherwise. `linkClkEn` stays 0 until `wakeAck` is pulsed. In the cycle after the acknowledge, `linkClkEn`=1, `txInhibit`=0 and `nmiReq`=0.
- R6: On a deep-sleep wake, `rxIntact` takes the value that the end-of-frame-seen flag had when deep sleep was entered.
- R7: The end-of-frame-seen flag is set by `eofReadStb` and cleared by any change (rising or falling) of the synchronized bus level. When both occur in the same cycle, the clear wins.
- R8: If `cpuWaitStb` arrives in run with `txBusy`=1, `sleepErr` is set and the block stays in run (`txInhibit`=0, `linkClkEn`=1).
- R9: `wakeIrq` and `sleepErr` hold until a `wakeAck` pulse; they read 0 in the cycle after it.
- R10: A falling bus edge does not end light sleep. A rising bus edge in run raises no interrupt. A `cpuWaitStb` that arrives while the block is asleep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst | input | 1 | Synchronous active-high reset |
| busRx | input | 1 | Received bus level, asynchronous (1 = active) |
| cpuWaitStb | input | 1 | One-cycle strobe: the CPU executed its wait instruction |
| deepModeSel | input | 1 | Sleep tier select at the wait strobe (0 light, 1 deep) |
| txBusy | input | 1 | Link transmitter is mid-transmission |
| eofReadStb | input | 1 | One-cycle strobe: end-of-frame status was read |
| wakeAck | input | 1 | One-cycle acknowledge for the wake interrupt, the request and the error |
| linkClkEn | output | 1 | Clock enable for the link datapath |
| txInhibit | output | 1 | Link must not drive the bus |
| wakeIrq | output | 1 | Maskable wake interrupt from light sleep |
| nmiReq | output | 1 | Non-maskable wake request from deep sleep |
| nmiVector | output | 8 | Vector code of the non-maskable request (8'h20 while requested) |
| rxIntact | output | 1 | The waking message will be received intact |
| sleepErr | output | 1 | A sleep was requested during transmission |

## Verification
Two events can fall in the same cycle on the end-of-frame-seen flag: an `eofReadStb` pulse and a synchronized bus edge, which pull it opposite ways. The bench provokes the collision by driving the strobe in exactly the cycle in which the synchronized level differs from its delayed copy. That cycle is the second clock after `busRx` changes. The bench then enters deep sleep and wakes the block, and judges the outcome at the ports: `rxIntact` must read 0. A control case that pulses the strobe a few cycles after the edge must read 1. Random episodes then mix reads, bus wiggles, busy requests and both sleep tiers, each checked against a bench model of the flag.

// File: rtl/linkWakePkg.sv
package linkWakePkg;

  typedef enum logic [1:0] {
    PWR_RUN      = 2'd0,
    PWR_LIGHT    = 2'd1,
    PWR_DEEP     = 2'd2,
    PWR_DEEPWAKE = 2'd3
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureEof;  // deep sleep entered: freeze eof-seen flag
    logic markLight;   // light wake: message intact
    logic markDeep;    // deep wake: intact = frozen eof flag
  } dpStrobe_t;

endpackage

// File: rtl/linkWakeDatapath.sv
module linkWakeDatapath
  import linkWakePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VECTOR_W    = 8,
  parameter logic [VECTOR_W-1:0] NMI_CODE = 8'h20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busRx,
  input  logic                eofReadStb,
  input  dpStrobe_t           stb,
  input  logic                nmiActive,
  output logic                riseDet,
  output logic                rxIntact,
  output logic [VECTOR_W-1:0] nmiVector
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic syncLvl;
  logic lastLvl;
  logic anyEdge;
  logic eofSeen;
  logic eofAtEntry;
  logic intactQ;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (rst) syncQ[0] <= 1'b0;
        else     syncQ[0] <= busRx;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (rst) syncQ[g] <= 1'b0;
        else     syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign syncLvl = syncQ[LAST];

  always_ff @(posedge clk) begin
    if (rst) lastLvl <= 1'b0;
    else     lastLvl <= syncLvl;
  end

  assign riseDet = syncLvl & ~lastLvl;
  assign anyEdge = syncLvl ^ lastLvl;

  // bus activity beats a simultaneous status read
  always_ff @(posedge clk) begin
    if (rst)             eofSeen <= 1'b0;
    else if (anyEdge)    eofSeen <= 1'b0;
    else if (eofReadStb) eofSeen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 eofAtEntry <= 1'b0;
    else if (stb.captureEof) eofAtEntry <= eofSeen;
  end

  always_ff @(posedge clk) begin
    if (rst)                intactQ <= 1'b0;
    else if (stb.markLight) intactQ <= 1'b1;
    else if (stb.markDeep)  intactQ <= eofAtEntry;
  end

  assign rxIntact  = intactQ;
  assign nmiVector = nmiActive ? NMI_CODE : '0;

endmodule

// File: rtl/linkWakeControl.sv
module linkWakeControl
  import linkWakePkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cpuWaitStb,
  input  logic      deepModeSel,
  input  logic      txBusy,
  input  logic      wakeAck,
  input  logic      riseDet,
  output dpStrobe_t stb,
  output logic      linkClkEn,
  output logic      txInhibit,
  output logic      wakeIrq,
  output logic      nmiReq,
  output logic      sleepErr
);

  pwrState_t state, stateNxt;
  logic sleepOk;
  logic badSleep;
  logic lightWake;

  assign sleepOk   = (state == PWR_RUN) && cpuWaitStb && !txBusy;
  assign badSleep  = (state == PWR_RUN) && cpuWaitStb && txBusy;
  assign lightWake = (state == PWR_LIGHT) && riseDet;

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      PWR_RUN: begin
        if (sleepOk) begin
          stateNxt       = deepModeSel ? PWR_DEEP : PWR_LIGHT;
          stb.captureEof = deepModeSel;
        end
      end
      PWR_LIGHT: begin
        if (riseDet) begin
          stateNxt      = PWR_RUN;
          stb.markLight = 1'b1;
        end
      end
      PWR_DEEP: begin
        if (riseDet) begin
          stateNxt     = PWR_DEEPWAKE;
          stb.markDeep = 1'b1;
        end
      end
      PWR_DEEPWAKE: begin
        if (wakeAck) stateNxt = PWR_RUN;
      end
      default: stateNxt = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PWR_RUN;
    else     state <= stateNxt;
  end

  always_ff @(posedge clk) begin
    if (rst)            wakeIrq <= 1'b0;
    else if (lightWake) wakeIrq <= 1'b1;
    else if (wakeAck)   wakeIrq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)           sleepErr <= 1'b0;
    else if (badSleep) sleepErr <= 1'b1;
    else if (wakeAck)  sleepErr <= 1'b0;
  end

  assign linkClkEn = !((state == PWR_DEEP) || (state == PWR_DEEPWAKE));
  assign txInhibit = (state != PWR_RUN);
  assign nmiReq    = (state == PWR_DEEPWAKE);

endmodule

// File: rtl/linkWakeCtl.sv
module linkWakeCtl
  import linkWakePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VECTOR_W    = 8,
  parameter logic [VECTOR_W-1:0] NMI_CODE = 8'h20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busRx,
  input  logic                cpuWaitStb,
  input  logic                deepModeSel,
  input  logic                txBusy,
  input  logic                eofReadStb,
  input  logic                wakeAck,
  output logic                linkClkEn,
  output logic                txInhibit,
  output logic                wakeIrq,
  output logic                nmiReq,
  output logic [VECTOR_W-1:0] nmiVector,
  output logic                rxIntact,
  output logic                sleepErr
);

  dpStrobe_t stb;
  logic riseDet;

  linkWakeControl uCtl (
    .clk        (clk),
    .rst        (rst),
    .cpuWaitStb (cpuWaitStb),
    .deepModeSel(deepModeSel),
    .txBusy     (txBusy),
    .wakeAck    (wakeAck),
    .riseDet    (riseDet),
    .stb        (stb),
    .linkClkEn  (linkClkEn),
    .txInhibit  (txInhibit),
    .wakeIrq    (wakeIrq),
    .nmiReq     (nmiReq),
    .sleepErr   (sleepErr)
  );

  linkWakeDatapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .VECTOR_W   (VECTOR_W),
    .NMI_CODE   (NMI_CODE)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .busRx     (busRx),
    .eofReadStb(eofReadStb),
    .stb       (stb),
    .nmiActive (nmiReq),
    .riseDet   (riseDet),
    .rxIntact  (rxIntact),
    .nmiVector (nmiVector)
  );

endmodule

// File: rtl/linkWakeCtl_chk.sv
module linkWakeCtl_chk #(
  parameter int VECTOR_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                busRx,
  input logic                cpuWaitStb,
  input logic                deepModeSel,
  input logic                txBusy,
  input logic                eofReadStb,
  input logic                wakeAck,
  input logic                linkClkEn,
  input logic                txInhibit,
  input logic                wakeIrq,
  input logic                nmiReq,
  input logic [VECTOR_W-1:0] nmiVector,
  input logic                rxIntact,
  input logic                sleepErr
);

  AST_RESET_RUN: assert property (@(posedge clk)
    $past(rst) && !rst |-> linkClkEn && !txInhibit && !wakeIrq && !nmiReq && !sleepErr); // R1

  AST_LIGHT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    cpuWaitStb && !txBusy && !deepModeSel && !txInhibit |=> txInhibit && linkClkEn); // R2

  AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    cpuWaitStb && !txBusy && deepModeSel && !txInhibit |=> txInhibit && !linkClkEn); // R4

  AST_CLK_OFF_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    !linkClkEn |-> txInhibit); // R4

  AST_NMI_CLK_OFF: assert property (@(posedge clk) disable iff (rst)
    nmiReq |-> !linkClkEn && nmiVector == 8'h20); // R5

  AST_VECTOR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !nmiReq |-> nmiVector == '0); // R5

  AST_NMI_RELEASE: assert property (@(posedge clk) disable iff (rst)
    nmiReq && wakeAck |=> !nmiReq && linkClkEn && !txInhibit); // R5

  AST_BUSY_ERROR: assert property (@(posedge clk) disable iff (rst)
    cpuWaitStb && txBusy && !txInhibit |=> sleepErr && !txInhibit && linkClkEn); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    wakeIrq && !wakeAck |=> wakeIrq); // R9

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    sleepErr && !wakeAck |=> sleepErr); // R9

endmodule

bind linkWakeCtl linkWakeCtl_chk #(.VECTOR_W(VECTOR_W)) uChk (.*);

// File: tb/linkWakeCtl_test.sv
module linkWakeCtl_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busRx = 1'b0;
  logic cpuWaitStb = 1'b0;
  logic deepModeSel = 1'b0;
  logic txBusy = 1'b0;
  logic eofReadStb = 1'b0;
  logic wakeAck = 1'b0;
  logic linkClkEn, txInhibit, wakeIrq, nmiReq, rxIntact, sleepErr;
  logic [7:0] nmiVector;

  int checks = 0;
  int errors = 0;
  logic expEof = 1'b0;

  always #10 clk = ~clk;

  linkWakeCtl uut (
    .clk(clk), .rst(rst), .busRx(busRx), .cpuWaitStb(cpuWaitStb),
    .deepModeSel(deepModeSel), .txBusy(txBusy), .eofReadStb(eofReadStb),
    .wakeAck(wakeAck), .linkClkEn(linkClkEn), .txInhibit(txInhibit),
    .wakeIrq(wakeIrq), .nmiReq(nmiReq), .nmiVector(nmiVector),
    .rxIntact(rxIntact), .sleepErr(sleepErr)
  );

  function automatic logic [7:0] expVector(input logic req);
    return req ? 8'h20 : 8'h00;
  endfunction

  function automatic logic expIntact(input logic deep, input logic eofAtEntry);
    return deep ? eofAtEntry : 1'b1;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setBus(input logic v);
    if (busRx !== v) expEof = 1'b0;
    busRx = v;
  endtask

  task automatic pulseWait(input logic deep, input logic busy);
    cpuWaitStb = 1'b1; deepModeSel = deep; txBusy = busy;
    cyc(1);
    cpuWaitStb = 1'b0; txBusy = 1'b0;
  endtask

  task automatic pulseAck();
    wakeAck = 1'b1; cyc(1); wakeAck = 1'b0;
  endtask

  task automatic pulseEof();
    eofReadStb = 1'b1; cyc(1); eofReadStb = 1'b0;
    expEof = 1'b1;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    check("R1 clkEn", linkClkEn, 1);
    check("R1 inhibit", txInhibit, 0);
    check("R1 flags", {wakeIrq, nmiReq, rxIntact, sleepErr}, 0);
    check("R1 vector", nmiVector, 0);

    // R10 rising edge in run raises nothing
    setBus(1); cyc(4);
    check("R10 run edge", {wakeIrq, nmiReq, txInhibit}, 0);

    // R2 light entry with bus high, R10 falling edge ignored
    pulseWait(0, 0);
    check("R2 inhibit", txInhibit, 1);
    check("R2 clkEn", linkClkEn, 1);
    setBus(0); cyc(5);
    check("R10 falling edge", {txInhibit, wakeIrq}, 2'b10);
    pulseWait(1, 0);
    check("R10 wait in sleep", {linkClkEn, txInhibit}, 2'b11);

    // R3 light wake latency
    setBus(1); cyc(2);
    check("R3 not yet", wakeIrq, 0);
    cyc(1);
    check("R3 irq", wakeIrq, 1);
    check("R3 run", txInhibit, 0);
    check("R3 intact", rxIntact, expIntact(0, 0));
    // R9 hold until ack
    cyc(4);
    check("R9 irq held", wakeIrq, 1);
    pulseAck();
    check("R9 irq cleared", wakeIrq, 0);

    // R4/R5/R6 deep with eof read after last activity
    setBus(0); cyc(4);
    pulseEof(); cyc(2);
    pulseWait(1, 0);
    check("R4 clkEn", linkClkEn, 0);
    check("R4 inhibit", txInhibit, 1);
    check("R5 vector idle", nmiVector, expVector(0));
    setBus(1); cyc(3);
    check("R5 nmi", nmiReq, 1);
    check("R5 vector", nmiVector, expVector(1));
    check("R6 intact set", rxIntact, expIntact(1, 1));
    cyc(5);
    check("R5 clk stays off", linkClkEn, 0);
    pulseAck();
    check("R5 release", {linkClkEn, txInhibit, nmiReq}, 3'b100);

    // R7 strobe in the same cycle as synchronized edge: edge wins
    busRx = 1'b0; expEof = 1'b0;
    cyc(1); cyc(1);
    eofReadStb = 1'b1; cyc(1); eofReadStb = 1'b0;
    cyc(2);
    pulseWait(1, 0);
    setBus(1); cyc(3);
    check("R7 collision", rxIntact, 0);
    pulseAck();

    // R6/R7 read followed by bus activity
    setBus(0); cyc(4);
    pulseEof();
    setBus(1); cyc(4); setBus(0); cyc(4);
    pulseWait(1, 0);
    setBus(1); cyc(3);
    check("R6 stale read", rxIntact, expIntact(1, expEof));
    pulseAck();

    // R8 busy request
    pulseWait(0, 1);
    check("R8 err", sleepErr, 1);
    check("R8 stays run", {txInhibit, linkClkEn}, 2'b01);
    cyc(3);
    check("R9 err held", sleepErr, 1);
    pulseAck();
    check("R9 err cleared", sleepErr, 0);

    // random episodes
    for (int ep = 0; ep < 40; ep++) begin
      logic deep, busy;
      deep = 1'($urandom % 2);
      busy = ($urandom % 4) == 0;
      if (busRx) begin setBus(0); cyc(4); end
      if ($urandom % 2) begin pulseEof(); cyc(1); end
      if (($urandom % 3) == 0) begin setBus(1); cyc(4); setBus(0); cyc(4); end
      pulseWait(deep, busy);
      if (busy) begin
        check("R8 rand err", {sleepErr, txInhibit}, 2'b10);
        pulseAck();
        check("R9 rand clear", sleepErr, 0);
      end else begin
        check("R2 R4 rand entry", {linkClkEn, txInhibit}, {!deep, 1'b1});
        begin
          logic eofAtEntry;
          eofAtEntry = expEof;
          setBus(1); cyc(3);
          if (deep) begin
            check("R5 rand nmi", {nmiReq, linkClkEn}, 2'b10);
            check("R5 rand vector", nmiVector, expVector(1));
            check("R6 rand intact", rxIntact, expIntact(1, eofAtEntry));
          end else begin
            check("R3 rand irq", {wakeIrq, txInhibit}, 2'b10);
            check("R3 rand intact", rxIntact, expIntact(0, eofAtEntry));
          end
        end
        pulseAck();
        check("R9 R5 rand ack", {wakeIrq, nmiReq, linkClkEn}, 3'b001);
      end
    end

    finishRun();
  end

endmodule